// File: doc/BRIEF.md
# Gated Prescaled Period Timer

This block is a 16-bit up-counter with a 16-bit period register and a sticky event flag. It can count the bus clock or edges of an external clock input. Counts pass through a prescaler that divides by 1, 8, 64 or 256. When the count has reached the period value, the next counted step returns it to zero and raises the event flag. In gated mode the bus clock is counted only while a gate input is high, and the flag marks the end of each gate pulse instead of a period match.

Software writes a control word, the count, the period and a flag-clear location over a simple write port. The control word has three extra addresses that clear, set or invert only the bits written as ones, so single bits can be changed without a read-modify-write. External edges can be counted after a two-flop synchronizer (synchronous mode), or straight from a one-flop edge detector (asynchronous mode, modelled at bus-clock resolution).

Top module: `prd_timer`

## Requirements
- R1: After reset the control word reads 0, the count reads 0, the period reads 16'hFFFF and the event flag is low.
- R2: A write to address 0 loads the control word in full. Bit 15 enables counting, bit 7 selects gated mode, bits 5:4 select the prescale, bit 2 selects synchronized external counting and bit 1 selects the external clock (1) or the bus clock (0).
- R3: Address 1 clears, address 2 sets and address 3 inverts the control bits written as ones. All other bits keep their value.
- R4: With the bus clock selected and no prescale, the count rises by one on each clock edge after the enable write. When the count equals the period, the next step loads zero and sets the event flag.
- R5: Prescale codes 00, 01, 10 and 11 advance the count once every 1, 8, 64 and 256 source events.
- R6: In gated mode the count advances only on edges where the gate input is high. The flag is set on the first edge after the gate goes low, and a period match does not set it.
- R7: With the external clock selected, the gate bit and the gate input have no effect on the count or the flag.
- R8: In synchronized external mode a rising edge of the external clock is counted on the third bus-clock edge after it. In asynchronous external mode it is counted on the first.
- R9: Clearing the enable bit sets the count and the prescaler to zero on the next edge. While disabled, nothing is counted.
- R10: Writes to the count (address 4) and to the period (address 5) take effect on the write edge, whether the timer is enabled or not.
- R11: The event flag stays set until a write to address 6 with bit 0 at 1. A write there with bit 0 at 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Write address (0 ctrl, 1 clear, 2 set, 3 invert, 4 count, 5 period, 6 flag clear) |
| bus_wdata | input | 16 | Write data |
| ext_clk | input | 1 | External clock input |
| gate_in | input | 1 | Gate input for gated mode |
| ctrl_q | output | 16 | Control word |
| count_q | output | 16 | Current count |
| period_q | output | 16 | Period value |
| event_flag | output | 1 | Sticky event flag |

## Verification
A prescaler that is not reset, or that has the wrong limit, shows as a count that is one step early or late after a number of events that the bench can predict. The bench checks this within eight edges at divide-by-8, and after re-enabling. A wrong synchronizer depth shows as a one- or two-edge shift in when an external edge reaches count_q. A gate falling-edge detector that fires in the wrong mode shows as event_flag rising on the next edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W   = 16;
  localparam int B_ON     = 15;
  localparam int B_GATE   = 7;
  localparam int B_PS_LO  = 4;
  localparam int B_SYNC   = 2;
  localparam int B_CS     = 1;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CLR    = 3'd1,
    A_SET    = 3'd2,
    A_INV    = 3'd3,
    A_COUNT  = 3'd4,
    A_PERIOD = 3'd5,
    A_FLAG   = 3'd6
  } addr_e;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int W = CTRL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr) begin
      case (addr)
        A_CTRL:  ctrl <= wdata;
        A_CLR:   ctrl <= ctrl & ~wdata;
        A_SET:   ctrl <= ctrl | wdata;
        A_INV:   ctrl <= ctrl ^ wdata;
        default: ctrl <= ctrl;
      endcase
    end
  end

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_SET) |=> ((ctrl & $past(wdata)) == $past(wdata)));
  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_CLR) |=> ((ctrl & $past(wdata)) == '0));
  // R3
  inv_alias_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == A_INV) |=> ((ctrl ^ $past(ctrl)) == $past(wdata)));
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int PS_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       on,
  input  logic       gate_en,
  input  logic       use_ext,
  input  logic       sync_en,
  input  logic [1:0] ps_sel,
  input  logic       ext_clk,
  input  logic       gate_in,
  output logic       tick,
  output logic       gate_fall
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES:0] ext_sync;
  logic                 ext_raw_d;
  logic                 gate_d;
  logic [PS_W-1:0]      ps_cnt;
  logic [PS_W-1:0]      ps_lim;
  logic                 src_pulse;
  logic                 edge_sync;
  logic                 edge_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_sync  <= '0;
      ext_raw_d <= 1'b0;
      gate_d    <= 1'b0;
    end else begin
      ext_sync  <= {ext_sync[SYNC_STAGES-1:0], ext_clk};
      ext_raw_d <= ext_clk;
      gate_d    <= gate_in;
    end
  end

  assign edge_sync = ext_sync[SYNC_STAGES-1] & ~ext_sync[SYNC_STAGES];
  assign edge_raw  = ext_clk & ~ext_raw_d;

  always_comb begin
    if (use_ext)      src_pulse = sync_en ? edge_sync : edge_raw;
    else if (gate_en) src_pulse = gate_in;
    else              src_pulse = 1'b1;
  end

  always_comb begin
    case (ps_sel)
      2'd0:    ps_lim = PS_W'(0);
      2'd1:    ps_lim = PS_W'(7);
      2'd2:    ps_lim = PS_W'(63);
      default: ps_lim = PS_W'(255);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !on) begin
      ps_cnt <= '0;
    end else if (src_pulse) begin
      ps_cnt <= (ps_cnt >= ps_lim) ? '0 : ps_cnt + 1'b1;
    end
  end

  assign tick      = on & src_pulse & (ps_cnt >= ps_lim);
  assign gate_fall = on & gate_en & ~use_ext & gate_d & ~gate_in;

  // R5
  ps_range_chk: assert property (@(posedge clk) disable iff (rst)
    ps_cnt <= ps_lim || $changed(ps_sel));
  // R9
  ps_off_chk: assert property (@(posedge clk) disable iff (rst)
    !on |=> ps_cnt == '0);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         on,
  input  logic         gated_mode,
  input  logic         tick,
  input  logic         gate_fall,
  input  logic         wr_count,
  input  logic         wr_period,
  input  logic         wr_flag_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] period,
  output logic         flag
);
  logic on_d;
  logic wrap;

  assign wrap = tick & (count == period);

  always_ff @(posedge clk) begin
    if (rst) on_d <= 1'b0;
    else     on_d <= on;
  end

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (wr_count)    count <= wdata;
    else if (on_d && !on) count <= '0;
    else if (wrap)        count <= '0;
    else if (tick)        count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            period <= '1;
    else if (wr_period) period <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                                  flag <= 1'b0;
    else if ((wrap && !gated_mode) || gate_fall) flag <= 1'b1;
    else if (wr_flag_clr)                     flag <= 1'b0;
  end

  // R9
  off_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (on_d && !on && !wr_count) |=> count == '0);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_count && !(on_d && !on)) |=> $stable(count));
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !wr_flag_clr) |=> flag);
  // R6
  gated_no_match_chk: assert property (@(posedge clk) disable iff (rst)
    (gated_mode && !gate_fall && !flag) |=> !flag);
endmodule

// File: rtl/prd_timer.sv
module prd_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  input  logic             ext_clk,
  input  logic             gate_in,
  output logic [15:0]      ctrl_q,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] period_q,
  output logic             event_flag
);
  logic tick;
  logic gate_fall;
  logic on;
  logic gate_en;
  logic use_ext;

  tmr_ctrl_regs #(.W(CTRL_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .ctrl  (ctrl_q)
  );

  assign on      = ctrl_q[B_ON];
  assign gate_en = ctrl_q[B_GATE];
  assign use_ext = ctrl_q[B_CS];

  tmr_tick_gen #(.PS_W(PS_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .on        (on),
    .gate_en   (gate_en),
    .use_ext   (use_ext),
    .sync_en   (ctrl_q[B_SYNC]),
    .ps_sel    (ctrl_q[B_PS_LO+1:B_PS_LO]),
    .ext_clk   (ext_clk),
    .gate_in   (gate_in),
    .tick      (tick),
    .gate_fall (gate_fall)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .on          (on),
    .gated_mode  (gate_en & ~use_ext),
    .tick        (tick),
    .gate_fall   (gate_fall),
    .wr_count    (bus_wr && bus_addr == A_COUNT),
    .wr_period   (bus_wr && bus_addr == A_PERIOD),
    .wr_flag_clr (bus_wr && bus_addr == A_FLAG && bus_wdata[0]),
    .wdata       (bus_wdata[CNT_W-1:0]),
    .count       (count_q),
    .period      (period_q),
    .flag        (event_flag)
  );
endmodule

// File: tb/prd_timer_test.sv
module prd_timer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        ext_clk = 1'b0;
  logic        gate_in = 1'b0;
  logic [15:0] ctrl_q, count_q, period_q;
  logic        event_flag;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prd_timer uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ext_clk(ext_clk), .gate_in(gate_in),
    .ctrl_q(ctrl_q), .count_q(count_q), .period_q(period_q),
    .event_flag(event_flag)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart();
    wr(3'd0, 16'h0000);
    wr(3'd4, 16'h0000);
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'h0001);
    ext_clk = 1'b0; gate_in = 1'b0;
    edges(3);
  endtask

  task automatic t_reset();
    check("R1 ctrl", ctrl_q, 16'h0000);
    check("R1 count", count_q, 16'h0000);
    check("R1 period", period_q, 16'hFFFF);
    check("R1 flag", {15'd0, event_flag}, 16'h0000);
  endtask

  task automatic t_aliases();
    wr(3'd0, 16'h0030);
    check("R2 direct write", ctrl_q, 16'h0030);
    wr(3'd2, 16'h8000);
    check("R3 set alias", ctrl_q, 16'h8030);
    wr(3'd1, 16'h0010);
    check("R3 clear alias", ctrl_q, 16'h8020);
    wr(3'd3, 16'h8022);
    check("R3 invert alias", ctrl_q, 16'h0002);
    restart();
  endtask

  task automatic t_wrap();
    wr(3'd5, 16'd4);
    check("R10 period write", period_q, 16'd4);
    wr(3'd0, 16'h8000);
    edges(3);
    check("R4 count after 3", count_q, 16'd3);
    check("R4 no flag yet", {15'd0, event_flag}, 16'd0);
    edges(2);
    check("R4 wrap to zero", count_q, 16'd0);
    check("R4 flag on wrap", {15'd0, event_flag}, 16'd1);
    wr(3'd6, 16'h0000);
    check("R11 zero write keeps flag", {15'd0, event_flag}, 16'd1);
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'h0001);
    check("R11 flag cleared", {15'd0, event_flag}, 16'd0);
    restart();
  endtask

  task automatic t_prescale();
    int c;
    wr(3'd0, 16'h8010);
    edges(7);
    check("R5 div8 before 8th", count_q, 16'd0);
    edges(1);
    check("R5 div8 at 8th", count_q, 16'd1);
    restart();
    wr(3'd0, 16'h8020);
    edges(128);
    check("R5 div64", count_q, 16'd2);
    restart();
    wr(3'd0, 16'h8030);
    edges(255);
    c = count_q;
    check("R5 div256 before", c[15:0], 16'd0);
    edges(1);
    check("R5 div256 at 256", count_q, 16'd1);
    restart();
  endtask

  task automatic t_disable();
    wr(3'd0, 16'h8010);
    edges(4);
    wr(3'd0, 16'h0010);
    edges(1);
    check("R9 count zero after disable", count_q, 16'd0);
    wr(3'd4, 16'd9);
    edges(3);
    check("R10 count write while off", count_q, 16'd9);
    check("R9 no count while off", count_q, 16'd9);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'h8010);
    edges(7);
    check("R9 prescaler cleared", count_q, 16'd0);
    edges(1);
    check("R9 prescaler fresh 8", count_q, 16'd1);
    restart();
  endtask

  task automatic t_gated();
    wr(3'd5, 16'd2);
    wr(3'd0, 16'h8080);
    edges(3);
    check("R6 no count gate low", count_q, 16'd0);
    gate_in = 1'b1;
    edges(2);
    check("R6 counts while high", count_q, 16'd2);
    edges(1);
    check("R6 match no flag", {15'd0, event_flag}, 16'd0);
    gate_in = 1'b0;
    edges(1);
    check("R6 flag at gate fall", {15'd0, event_flag}, 16'd1);
    check("R6 hold after fall", count_q, 16'd0);
    restart();
  endtask

  task automatic t_ext();
    wr(3'd0, 16'h8082);
    gate_in = 1'b1; edges(2); gate_in = 1'b0; edges(2);
    check("R7 gate ignored count", count_q, 16'd0);
    check("R7 gate ignored flag", {15'd0, event_flag}, 16'd0);
    ext_clk = 1'b1;
    edges(1);
    check("R8 async first edge", count_q, 16'd1);
    ext_clk = 1'b0; edges(2);
    check("R8 async single count", count_q, 16'd1);
    restart();
    wr(3'd0, 16'h8006);
    ext_clk = 1'b1;
    edges(2);
    check("R8 sync not yet", count_q, 16'd0);
    edges(1);
    check("R8 sync third edge", count_q, 16'd1);
    ext_clk = 1'b0; edges(3);
    check("R8 sync single count", count_q, 16'd1);
    restart();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_aliases();
    t_wrap();
    t_prescale();
    t_disable();
    t_gated();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule